// File: doc/BRIEF.md
# Scan-Line Panel Timing Generator

This block drives a row-multiplexed LED panel from a single system clock. For every row pair it reads one upper and one lower pixel per column through a simple fetch port (column, row, subframe), shifts them onto two three-bit colour buses with a divided panel clock, and pulses a latch strobe once the full line is in the panel. It then moves the row address to the row just latched and opens the active-low output enable for a fixed window. The window overlaps the shifting of the next line, so no gated clock is needed.

All panel signals come from registers in one clock domain. The panel clock runs at half the system rate. Each data change lands one system cycle (half a pixel period) before the rising edge that samples it. A line takes WIDTH+1 pixel periods: WIDTH shifting periods and one latch period with no clock edge. The enable is low for WIDTH-3 pixel periods of each line, in the same place every time. After the last row pair, a subframe index advances modulo 2^SUB_W and goes to the fetch port, so an external source can time-dither colour depth.

Top module: `panel_scan_ctrl`

## Requirements
- R1: While reset is asserted, oe_n is 1, latch and panel_clk are 0, and addr is 0.
- R2: Each line has WIDTH rising edges of panel_clk, for columns 0 to WIDTH-1 in ascending order. On each edge, rgb_top carries pix_up and rgb_bot carries pix_lo as fetched for that column. Bit 2 is red, bit 1 is green and bit 0 is blue. The colour buses do not change while panel_clk is high.
- R3: After the WIDTH-th rising panel_clk edge of a line, latch goes high for one pixel period (two system cycles), and panel_clk stays low for that whole time.
- R4: latch is high, and addr changes, only while oe_n is 1.
- R5: Each time oe_n is low, it stays low for exactly 2*(WIDTH-3) system cycles, on every line.
- R6: While oe_n is low, addr equals the row pair most recently latched. Rows are latched in order 0 to ROWS/2-1 and then wrap. addr is $clog2(ROWS/2) bits wide, so a 64-row panel uses five address lines.
- R7: oe_n stays high from reset until the first latch pulse.
- R8: After the latch of the last row pair, pix_sub increments modulo 2^SUB_W (32 by default). The next line's pixels are fetched with the new index.
- R9: Successive latch pulses start exactly 2*(WIDTH+1) system cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pix_col | output | $clog2(WIDTH) | Column being fetched |
| pix_row | output | $clog2(ROWS/2) | Row pair being fetched |
| pix_sub | output | SUB_W | Subframe index being fetched |
| pix_up | input | 3 | Fetched upper-half pixel {R,G,B} |
| pix_lo | input | 3 | Fetched lower-half pixel {R,G,B} |
| panel_clk | output | 1 | Panel shift clock, half system rate |
| rgb_top | output | 3 | Upper-half colour lines {R,G,B} |
| rgb_bot | output | 3 | Lower-half colour lines {R,G,B} |
| latch | output | 1 | Latch strobe, high one pixel period |
| oe_n | output | 1 | Active-low display enable |
| addr | output | $clog2(ROWS/2) | Row-pair address |

## Verification
The bench uses WIDTH=8 and ROWS=64. This gives short lines, so the three-period enable margin and the latch period are exercised thousands of times. It also gives the full five-bit address range, including the wrap from row 31 to row 0. With the default SUB_W of 5, 33 complete subframes run, which carries pix_sub through its wrap from 31 back to 0. The wrap shows up in the fetched pixel values, because the test pattern depends on every subframe bit.

// File: rtl/panel_scan_pkg.sv
package panel_scan_pkg;
  // one colour triple: bit 2 red, bit 1 green, bit 0 blue
  typedef logic [2:0] rgb_t;
  // system cycles per pixel period
  localparam int unsigned SYS_PER_PIX = 2;
endpackage

// File: rtl/panel_rst_sync.sv
module panel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/panel_scan_timer.sv
module panel_scan_timer #(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned TW = $clog2(WIDTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          phase,
  output logic [TW-1:0] tick,
  output logic          shift_tick,
  output logic          line_end
);
  localparam logic [TW-1:0] LAST_TICK = TW'(WIDTH);

  logic          phase_q, phase_d;
  logic [TW-1:0] tick_q, tick_d;

  assign line_end   = (tick_q == LAST_TICK);
  assign shift_tick = (tick_q < LAST_TICK);

  always_comb begin
    phase_d = ~phase_q;
    tick_d  = tick_q;
    if (phase_q) begin
      tick_d = line_end ? '0 : tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      tick_q  <= '0;
    end else begin
      phase_q <= phase_d;
      tick_q  <= tick_d;
    end
  end

  assign phase = phase_q;
  assign tick  = tick_q;

  // R9
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= LAST_TICK);

  // R9
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_q |=> $stable(tick_q));
endmodule

// File: rtl/panel_row_seq.sv
module panel_row_seq #(
  parameter int unsigned ROW_PAIRS = 32,
  parameter int unsigned SUB_W     = 5,
  localparam int unsigned ROW_W = (ROW_PAIRS > 1) ? $clog2(ROW_PAIRS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [ROW_W-1:0] load_row,
  output logic [ROW_W-1:0] disp_row,
  output logic [SUB_W-1:0] sub,
  output logic             primed
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROW_PAIRS - 1);

  logic [ROW_W-1:0] load_q, load_d, disp_q, disp_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             primed_q, primed_d;

  always_comb begin
    load_d   = load_q;
    disp_d   = disp_q;
    sub_d    = sub_q;
    primed_d = primed_q;
    if (advance) begin
      disp_d   = load_q;
      primed_d = 1'b1;
      if (load_q == LAST_ROW) begin
        load_d = '0;
        sub_d  = sub_q + 1'b1;
      end else begin
        load_d = load_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '0;
      disp_q   <= '0;
      sub_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      load_q   <= load_d;
      disp_q   <= disp_d;
      sub_q    <= sub_d;
      primed_q <= primed_d;
    end
  end

  assign load_row = load_q;
  assign disp_row = disp_q;
  assign sub      = sub_q;
  assign primed   = primed_q;

  // R8
  sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && load_q == LAST_ROW && sub_q == {SUB_W{1'b1}}) |=> sub_q == '0);

  // R8
  sub_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q != LAST_ROW || !advance) |=> $stable(sub_q));

  // R6
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && load_q == LAST_ROW) |=> load_q == '0);
endmodule

// File: rtl/panel_out_stage.sv
module panel_out_stage
  import panel_scan_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned TW = $clog2(WIDTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase,
  input  logic [TW-1:0] tick,
  input  logic          shift_tick,
  input  logic          line_end,
  input  logic          primed,
  input  rgb_t          pix_up,
  input  rgb_t          pix_lo,
  output logic          panel_clk,
  output rgb_t          rgb_top,
  output rgb_t          rgb_bot,
  output logic          latch,
  output logic          oe_n
);
  localparam logic [TW-1:0] OE_FIRST = TW'(2);
  localparam logic [TW-1:0] OE_LAST  = TW'(WIDTH - 2);
  localparam int unsigned   OE_CYC   = SYS_PER_PIX * (WIDTH - 3);
  localparam int unsigned   CW       = $clog2(OE_CYC + 2);

  logic tick_en, oe_on;
  logic pclk_q, pclk_d, latch_q, latch_d, oe_n_q, oe_n_d;
  rgb_t top_q, top_d, bot_q, bot_d;

  assign tick_en = ~phase;
  assign oe_on   = primed && (tick >= OE_FIRST) && (tick <= OE_LAST);

  always_comb begin
    pclk_d  = phase & shift_tick;
    top_d   = top_q;
    bot_d   = bot_q;
    latch_d = latch_q;
    oe_n_d  = oe_n_q;
    if (tick_en) begin
      top_d   = shift_tick ? pix_up : '0;
      bot_d   = shift_tick ? pix_lo : '0;
      latch_d = line_end;
      oe_n_d  = ~oe_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q  <= 1'b0;
      top_q   <= '0;
      bot_q   <= '0;
      latch_q <= 1'b0;
      oe_n_q  <= 1'b1;
    end else begin
      pclk_q  <= pclk_d;
      top_q   <= top_d;
      bot_q   <= bot_d;
      latch_q <= latch_d;
      oe_n_q  <= oe_n_d;
    end
  end

  assign panel_clk = pclk_q;
  assign rgb_top   = top_q;
  assign rgb_bot   = bot_q;
  assign latch     = latch_q;
  assign oe_n      = oe_n_q;

  // checker counter for the enable window length
  logic [CW-1:0] low_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt_q <= '0;
    else if (!oe_n_q) low_cnt_q <= low_cnt_q + 1'b1;
    else             low_cnt_q <= '0;
  end

  // R5
  oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n_q) |-> low_cnt_q == CW'(OE_CYC));

  // R4
  latch_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |-> oe_n_q);

  // R3
  latch_noclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |-> !pclk_q);

  // R2
  rgb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_q |-> ($stable(top_q) && $stable(bot_q)));
endmodule

// File: rtl/panel_scan_ctrl.sv
module panel_scan_ctrl
  import panel_scan_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned ROWS  = 64,
  parameter int unsigned SUB_W = 5,
  localparam int unsigned ROW_PAIRS = ROWS / 2,
  localparam int unsigned ROW_W = (ROW_PAIRS > 1) ? $clog2(ROW_PAIRS) : 1,
  localparam int unsigned COL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [COL_W-1:0] pix_col,
  output logic [ROW_W-1:0] pix_row,
  output logic [SUB_W-1:0] pix_sub,
  input  logic [2:0]       pix_up,
  input  logic [2:0]       pix_lo,
  output logic             panel_clk,
  output logic [2:0]       rgb_top,
  output logic [2:0]       rgb_bot,
  output logic             latch,
  output logic             oe_n,
  output logic [ROW_W-1:0] addr
);
  localparam int unsigned TW = $clog2(WIDTH + 1);

  logic          rst_n_s;
  logic          phase, shift_tick, line_end, primed;
  logic [TW-1:0] tick;
  logic [ROW_W-1:0] load_row, disp_row;

  panel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  panel_scan_timer #(.WIDTH(WIDTH)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .phase      (phase),
    .tick       (tick),
    .shift_tick (shift_tick),
    .line_end   (line_end)
  );

  panel_row_seq #(.ROW_PAIRS(ROW_PAIRS), .SUB_W(SUB_W)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .advance  (~phase & line_end),
    .load_row (load_row),
    .disp_row (disp_row),
    .sub      (pix_sub),
    .primed   (primed)
  );

  panel_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .phase      (phase),
    .tick       (tick),
    .shift_tick (shift_tick),
    .line_end   (line_end),
    .primed     (primed),
    .pix_up     (pix_up),
    .pix_lo     (pix_lo),
    .panel_clk  (panel_clk),
    .rgb_top    (rgb_top),
    .rgb_bot    (rgb_bot),
    .latch      (latch),
    .oe_n       (oe_n)
  );

  assign pix_col = tick[COL_W-1:0];
  assign pix_row = load_row;
  assign addr    = disp_row;

  // R4
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!oe_n && $past(!oe_n)) |-> $stable(addr));

  // R7
  dark_until_primed_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !primed |-> oe_n);
endmodule

// File: tb/tb_panel_scan_ctrl.sv
module tb_panel_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 8;
  localparam int ROWS  = 64;
  localparam int SUBW  = 5;
  localparam int RP    = ROWS / 2;
  localparam int NSUB  = 33;
  localparam int RW    = $clog2(RP);
  localparam int CWID  = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CWID-1:0] pix_col;
  logic [RW-1:0]   pix_row;
  logic [SUBW-1:0] pix_sub;
  logic [2:0] pix_up, pix_lo;
  logic panel_clk, latch, oe_n;
  logic [2:0] rgb_top, rgb_bot;
  logic [RW-1:0] addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_scan_ctrl #(.WIDTH(W), .ROWS(ROWS), .SUB_W(SUBW)) dut (
    .clk(clk), .rst_n(rst_n),
    .pix_col(pix_col), .pix_row(pix_row), .pix_sub(pix_sub),
    .pix_up(pix_up), .pix_lo(pix_lo),
    .panel_clk(panel_clk), .rgb_top(rgb_top), .rgb_bot(rgb_bot),
    .latch(latch), .oe_n(oe_n), .addr(addr)
  );

  // pattern source standing in for the frame store
  function automatic logic [5:0] pattern(int c, int r, int s);
    logic [31:0] x;
    x = 32'(c * 7 + r * 13 + s * 29);
    return {x[2:0] ^ x[5:3] ^ x[8:6], x[3:1] ^ x[6:4] ^ 3'b101};
  endfunction

  always_comb {pix_up, pix_lo} = pattern(int'(pix_col), int'(pix_row), int'(pix_sub));

  int n_checks = 0;
  int n_fail   = 0;
  logic [5:0] pix_q[$];
  int         row_q[$];
  bit         timeout = 0;
  bit         done    = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: expected shift order and latch order
  task automatic push_expected();
    for (int s = 0; s < NSUB; s++)
      for (int r = 0; r < RP; r++) begin
        for (int c = 0; c < W; c++) pix_q.push_back(pattern(c, r, s % (1 << SUBW)));
        row_q.push_back(r);
      end
  endtask

  // monitor
  logic prev_pclk = 0, prev_latch = 0, prev_oe = 1;
  int   shift_cnt = 0, low_cnt = 0, since_latch = 0, n_latch = 0;
  bit   latch_seen = 0;
  int   last_addr = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      since_latch++;
      if (panel_clk && !prev_pclk) begin
        shift_cnt++;
        if (pix_q.size() > 0) begin
          logic [5:0] e;
          e = pix_q.pop_front();
          chk({rgb_top, rgb_bot} == e, "R2/R8 pixel pair", int'({rgb_top, rgb_bot}), int'(e));
        end
      end
      if (latch && panel_clk) chk(0, "R3 clock during latch", 1, 0);
      if (latch && !prev_latch) begin
        chk(shift_cnt == W, "R3 shifts before latch", shift_cnt, W);
        chk(oe_n == 1'b1, "R4 latch while dark", int'(oe_n), 1);
        if (n_latch > 0) chk(since_latch == 2 * (W + 1), "R9 latch spacing", since_latch, 2 * (W + 1));
        if (row_q.size() > 0) begin
          int er;
          er = row_q.pop_front();
          chk(int'(addr) == er, "R6 latched row", int'(addr), er);
        end
        shift_cnt = 0; since_latch = 0; n_latch++;
        latch_seen = 1; last_addr = int'(addr);
      end
      if (latch && prev_latch) chk(!panel_clk, "R3 latch width", int'(panel_clk), 0);
      if (!latch && prev_latch) chk(since_latch == 2, "R3 latch length", since_latch, 2);
      if (!oe_n) begin
        low_cnt++;
        chk(latch_seen, "R7 lit before first latch", 0, 1);
        if (int'(addr) != last_addr) chk(0, "R6 address while lit", int'(addr), last_addr);
        if (latch) chk(0, "R4 latch while lit", 1, 0);
      end
      if (oe_n && !prev_oe) begin
        chk(low_cnt == 2 * (W - 3), "R5 enable window", low_cnt, 2 * (W - 3));
        low_cnt = 0;
      end
      prev_pclk = panel_clk; prev_latch = latch; prev_oe = oe_n;
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 100000 && !done) begin
      timeout = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    end
  end

  initial begin
    push_expected();
    repeat (4) @(negedge clk);
    // R1 reset values
    chk(oe_n == 1'b1, "R1 oe_n in reset", int'(oe_n), 1);
    chk(latch == 1'b0, "R1 latch in reset", int'(latch), 0);
    chk(panel_clk == 1'b0, "R1 clock in reset", int'(panel_clk), 0);
    chk(addr == '0, "R1 addr in reset", int'(addr), 0);
    rst_n = 1'b1;
    wait (row_q.size() == 0 || timeout);
    repeat (10) @(negedge clk);
    done = 1;
    chk(n_latch == NSUB * RP, "R6 latch count", n_latch, NSUB * RP);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule